// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a frame of payload bytes into a byte-packed HDLC bit stream ready to be written into a modem transmit FIFO. A frame starts when the upstream source presents its first byte. The framer sends an opening flag, then the payload bits, then a CRC-16 check sequence. Whenever five one bits in a row appear in the payload or check sequence, it adds a zero bit. The frame ends with two flag patterns. The resulting bit stream is regrouped into bytes, least significant bit first.

The block works on one bit per clock. Each accepted payload byte takes one load cycle and eight bit cycles, plus one cycle for every inserted zero. Both edges of the block use a valid/ready handshake. The output byte register also acts as the back-pressure point for the whole bit engine. A one-cycle done pulse tells the surrounding logic that every byte of a frame has left the block.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Reset is synchronous and active low. In the cycle after a clock edge with `rst_n` low, `out_valid`, `in_ready` and `frame_done` are all low.
- R2: The first output byte of every frame is the flag value 0x7E. It is emitted before any payload bit.
- R3: The check sequence is CRC-16 with the reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to 0xFFFF over the payload bits, and complemented. Its low byte goes first and its high byte second, each least significant bit first.
- R4: After any five consecutive one bits in the payload or check sequence, one zero bit is inserted. The count of ones carries across payload byte boundaries, across the step from payload to check sequence, and past the last check-sequence bit.
- R5: The flag bits are never counted in the ones run and never stuffed. The run starts at zero after the opening flag, and the closing pattern 0x7E7E (16 bits) is sent unaltered.
- R6: Stuffed bits are packed into output bytes least significant bit first. A byte is offered each time eight bits have gathered.
- R7: Bits left over after the closing pattern that do not fill a byte are dropped. The next frame starts on a fresh byte boundary.
- R8: `in_ready` is low in any cycle where a zero bit is being inserted, and in any cycle where the output byte is held (`out_valid` high, `out_ready` low).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: `frame_done` is a single-cycle pulse. It comes after the last output byte of a frame has been accepted, and `out_valid` is low while it is high.
- R11: A payload byte is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_last` set on that byte makes it the final payload byte. A frame is started by `in_valid` rising while the framer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Framer takes the payload byte this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of the frame |
| out_valid | output | 1 | Packed output byte available |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Packed output byte, first bit in bit 0 |
| frame_done | output | 1 | One-cycle pulse after the last byte of a frame is accepted |

## Verification
The assertions assume the source follows the usual handshake: once it raises `in_valid` it holds the byte and `in_last` until they are taken, and every frame ends with a byte marked by `in_last`. The stimulus keeps to this. It raises `in_valid` only on a byte it has not yet offered and drops it only after a transfer. Every frame it builds ends with a marked byte, and the consumer may stall `out_ready` at any time. The consumer side is unconstrained, so the hold property on the output register is checked against arbitrary `out_ready` patterns.

// File: rtl/hdlc_tx_pkg.sv
// hdlc_tx_pkg: constants and the phase type shared by the transmit framer.
// Assumes byte-wide payload and a 16-bit reflected CRC.
package hdlc_tx_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          FCS_W       = 16;
    localparam logic [7:0]  FLAG_BYTE   = 8'h7E;
    localparam logic [15:0] CLOSE_PAT   = 16'h7E7E;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_RF = 16'h8408;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_OPEN  = 3'd1,
        PH_DATA  = 3'd2,
        PH_FCS   = 3'd3,
        PH_CLOSE = 3'd4,
        PH_DRAIN = 3'd5
    } tx_phase_e;

endpackage

// File: rtl/hdlc_crc16_serial.sv
// hdlc_crc16_serial: bit-serial reflected CRC-16 register.
// Assumes bits arrive least significant first; 'preset' has priority over 'step'.
module hdlc_crc16_serial
    import hdlc_tx_pkg::*;
#(
    parameter int          W      = FCS_W,
    parameter logic [15:0] POLY   = CRC_POLY_RF,
    parameter logic [15:0] PRESET = CRC_PRESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset,
    input  logic         step,
    input  logic         bit_in,
    output logic [W-1:0] crc
);

    logic         fb;
    logic [W-1:0] crc_next;

    // Next CRC value for one incoming bit.
    always_comb begin
        fb       = crc[0] ^ bit_in;
        crc_next = crc >> 1;
        if (fb) begin
            crc_next = crc_next ^ POLY[W-1:0];
        end
    end

    // CRC state register.
    always_ff @(posedge clk) begin
        if (!rst_n || preset) begin
            crc <= PRESET[W-1:0];
        end else if (step) begin
            crc <= crc_next;
        end
    end

endmodule

// File: rtl/hdlc_run_tracker.sv
// hdlc_run_tracker: counts consecutive stuffable one bits and requests a zero.
// Assumes every emitted bit is reported; bits not marked 'countable' end the run.
module hdlc_run_tracker #(
    parameter int RUN_LIMIT = 5,
    localparam int CNT_W    = $clog2(RUN_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             countable,
    output logic [CNT_W-1:0] run_cnt,
    output logic             insert_now
);

    // A full run means the next emitted bit must be a zero.
    assign insert_now = (run_cnt == CNT_W'(RUN_LIMIT));

    // Run length register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (bit_vld) begin
            if (countable && bit_val) begin
                run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/hdlc_bit_packer.sv
// hdlc_bit_packer: gathers bits LSB first into bytes and holds each byte for a
// valid/ready consumer. Assumes the producer sends a bit only when
// 'space' is high; 'flush' drops a partial byte.
module hdlc_bit_packer #(
    parameter int W    = 8,
    localparam int C_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_vld,
    input  logic         bit_val,
    input  logic         flush,
    output logic         space,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic [W-1:0]   acc_q;
    logic [W-1:0]   acc_next;
    logic [C_W-1:0] cnt_q;
    logic           full_now;

    assign space    = !out_valid || out_ready;
    assign full_now = bit_vld && (cnt_q == C_W'(W - 1));

    // Place the incoming bit at the current fill position.
    always_comb begin
        acc_next        = acc_q;
        acc_next[cnt_q] = bit_val;
    end

    // Accumulator and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (bit_vld) begin
            acc_q <= acc_next;
            cnt_q <= full_now ? '0 : cnt_q + 1'b1;
        end
    end

    // Output byte register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (full_now) begin
                out_valid <= 1'b1;
                out_data  <= acc_next;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
// hdlc_tx_framer: frames a payload byte stream as HDLC: opening flag, payload,
// complemented CRC-16, zero insertion after five ones, two closing flags,
// repacked LSB first into bytes. Assumes the source holds in_valid/in_data/
// in_last until taken and ends each frame with in_last. One bit per clock.
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    localparam int RUN_W    = $clog2(RUN_LIMIT + 1),
    localparam int IDX_W    = $clog2(FCS_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              frame_done
);

    tx_phase_e         phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] sh_q;
    logic              last_q;
    logic              have_q;

    logic              space;
    logic              stuff_now;
    logic [RUN_W-1:0]  run_cnt;
    logic              bit_vld;
    logic              bit_val;
    logic              countable;
    logic              crc_step;
    logic              crc_preset;
    logic              flush;
    logic [FCS_W-1:0]  crc;

    localparam logic [IDX_W-1:0] BYTE_END = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] FCS_END  = IDX_W'(FCS_W - 1);

    assign crc_preset = (phase_q == PH_OPEN);
    assign flush      = (phase_q == PH_DRAIN);

    // Choose the bit to emit this cycle and the handshake toward the source.
    always_comb begin
        bit_vld   = 1'b0;
        bit_val   = 1'b0;
        countable = 1'b0;
        crc_step  = 1'b0;
        in_ready  = 1'b0;
        if (space) begin
            unique case (phase_q)
                PH_OPEN: begin
                    bit_vld = 1'b1;
                    bit_val = FLAG_BYTE[idx_q[2:0]];
                end
                PH_DATA: begin
                    if (stuff_now) begin
                        bit_vld = 1'b1;
                    end else if (have_q) begin
                        bit_vld   = 1'b1;
                        bit_val   = sh_q[idx_q[2:0]];
                        countable = 1'b1;
                        crc_step  = 1'b1;
                    end else begin
                        in_ready = 1'b1;
                    end
                end
                PH_FCS: begin
                    bit_vld = 1'b1;
                    if (!stuff_now) begin
                        bit_val   = ~crc[idx_q];
                        countable = 1'b1;
                    end
                end
                PH_CLOSE: begin
                    bit_vld = 1'b1;
                    if (!stuff_now) begin
                        bit_val = CLOSE_PAT[idx_q];
                    end
                end
                default: ;
            endcase
        end
    end

    // Phase sequencing, payload byte holding and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            idx_q      <= '0;
            sh_q       <= '0;
            last_q     <= 1'b0;
            have_q     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    idx_q <= '0;
                    if (in_valid) begin
                        phase_q <= PH_OPEN;
                    end
                end
                PH_OPEN: begin
                    if (space) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == BYTE_END) begin
                            idx_q   <= '0;
                            have_q  <= 1'b0;
                            phase_q <= PH_DATA;
                        end
                    end
                end
                PH_DATA: begin
                    if (space && !stuff_now) begin
                        if (have_q) begin
                            idx_q <= idx_q + 1'b1;
                            if (idx_q == BYTE_END) begin
                                idx_q  <= '0;
                                have_q <= 1'b0;
                                if (last_q) begin
                                    phase_q <= PH_FCS;
                                end
                            end
                        end else if (in_valid) begin
                            sh_q   <= in_data;
                            last_q <= in_last;
                            have_q <= 1'b1;
                            idx_q  <= '0;
                        end
                    end
                end
                PH_FCS: begin
                    if (space && !stuff_now) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == FCS_END) begin
                            idx_q   <= '0;
                            phase_q <= PH_CLOSE;
                        end
                    end
                end
                PH_CLOSE: begin
                    if (space && !stuff_now) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == FCS_END) begin
                            idx_q   <= '0;
                            phase_q <= PH_DRAIN;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (!out_valid) begin
                        frame_done <= 1'b1;
                        phase_q    <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    hdlc_crc16_serial u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (crc_preset),
        .step   (crc_step),
        .bit_in (bit_val),
        .crc    (crc)
    );

    hdlc_run_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .countable  (countable),
        .run_cnt    (run_cnt),
        .insert_now (stuff_now)
    );

    hdlc_bit_packer #(.W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .flush     (flush),
        .space     (space),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
// hdlc_tx_framer_chk: temporal checks on the framer ports and on the link
// between the run tracker and the source handshake. Attached by bind.
module hdlc_tx_framer_chk #(
    parameter int RUN_LIMIT = 5,
    localparam int RUN_W    = $clog2(RUN_LIMIT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             frame_done,
    input logic             stuff_now,
    input logic [RUN_W-1:0] run_cnt
);

    // R1: leaving reset, nothing is offered.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !frame_done && !in_ready));

    // R4: the ones run never exceeds the limit.
    a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_W'(RUN_LIMIT));

    // R8: no payload byte is taken while a zero is being inserted.
    a_r8_no_take_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_now |-> !in_ready);

    // R8: no payload byte is taken while the output byte is stalled.
    a_r8_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: a stalled output byte holds.
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: frame_done only with the output empty.
    a_r10_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !out_valid);

    // R10: frame_done lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .frame_done (frame_done),
    .stuff_now  (stuff_now),
    .run_cnt    (run_cnt)
);

// File: tb/hdlc_tx_framer_tb_top.sv
`timescale 1ns/1ps
// hdlc_tx_framer_tb_top: drives frames, builds the expected byte stream with a
// behavioural model (bit queues, integer CRC) and compares every cycle.
module hdlc_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       frame_done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int in_idx = 0;
    int frame_bytes = 0;
    int frames_seen = 0;
    int n_frames = 0;
    int stall_mode = 0;
    bit took = 1'b0;

    logic [7:0] in_q[$];
    bit         lastf_q[$];
    logic [7:0] exp_q[$];
    int         exp_len_q[$];

    always #2 clk = ~clk;

    hdlc_tx_framer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .frame_done (frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Reference: expected output bytes for one frame.
    function automatic void add_frame(input logic [7:0] p[$]);
        int bits[$];
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] fcs;
        int run = 0;
        int nbytes;
        for (int b = 0; b < 8; b++) bits.push_back((8'h7E >> b) & 1);
        for (int i = 0; i < p.size(); i++) begin
            for (int b = 0; b < 8; b++) begin
                int v = (p[i] >> b) & 1;
                bit fb = crc[0] ^ v[0];
                crc = crc >> 1;
                if (fb) crc = crc ^ 16'h8408;
                bits.push_back(v);
                run = v ? run + 1 : 0;
                if (run == 5) begin bits.push_back(0); run = 0; end
            end
            in_q.push_back(p[i]);
            lastf_q.push_back(i == p.size() - 1);
        end
        fcs = ~crc;
        for (int b = 0; b < 16; b++) begin
            int v = (fcs >> b) & 1;
            bits.push_back(v);
            run = v ? run + 1 : 0;
            if (run == 5) begin bits.push_back(0); run = 0; end
        end
        for (int b = 0; b < 16; b++) bits.push_back((16'h7E7E >> b) & 1);
        nbytes = bits.size() / 8;
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] by = 8'h00;
            for (int b = 0; b < 8; b++) by[b] = bits[k*8 + b][0];
            exp_q.push_back(by);
        end
        exp_len_q.push_back(nbytes);
        n_frames++;
    endfunction

    // One clock: drive at the falling edge, observe the coming transfer.
    task automatic cycle();
        @(negedge clk);
        cycles++;
        if (took) begin
            in_idx++;
            in_valid = 1'b0;
            took = 1'b0;
        end
        out_ready = (stall_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        if (!in_valid && in_idx < in_q.size() && (stall_mode == 0 || ($urandom % 2) == 0)) begin
            in_valid = 1'b1;
            in_data  = in_q[in_idx];
            in_last  = lastf_q[in_idx];
        end
        #1;
        if (out_valid && !out_ready)
            check(!in_ready, "R8 in_ready during output stall", in_ready, 0);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected extra byte", out_data, 0);
            end else begin
                logic [7:0] e = exp_q.pop_front();
                // R3 R4 R5: FCS, stuffing and flag bytes are all inside this stream
                check(out_data == e, frame_bytes == 0 ? "R2 opening flag" : "R6 packed byte",
                      out_data, e);
            end
            frame_bytes++;
        end
        if (frame_done) begin
            int el = (exp_len_q.size() != 0) ? exp_len_q.pop_front() : -1;
            // R7: trailing partial bits dropped, so the byte count matches exactly
            check(frame_bytes == el, "R10 bytes per frame at done", frame_bytes, el);
            check(!out_valid, "R10 output empty at done", out_valid, 0);
            frame_bytes = 0;
            frames_seen++;
        end
        if (in_valid && in_ready) took = 1'b1;  // R11 transfer
    endtask

    initial begin
        logic [7:0] p[$];
        // Frame set: single zero byte; all ones (R4); flag-like payload (R5);
        // run across a byte boundary (R4); counting bytes; random lengths.
        p = {8'h00};                         add_frame(p);
        p = {8'hFF, 8'hFF, 8'hFF, 8'hFF};    add_frame(p);
        p = {8'h7E, 8'h7E, 8'h3F};           add_frame(p);
        p = {8'hF0, 8'h0F, 8'hF8, 8'h1F};    add_frame(p);
        p.delete();
        for (int i = 0; i < 16; i++) p.push_back(8'(i * 37));
        add_frame(p);
        for (int f = 0; f < 10; f++) begin
            int len = 1 + ($urandom % 12);
            p.delete();
            for (int i = 0; i < len; i++) p.push_back(8'($urandom));
            add_frame(p);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R1 out_valid in reset", out_valid, 0);
        check(!in_ready, "R1 in_ready in reset", in_ready, 0);
        check(!frame_done, "R1 frame_done in reset", frame_done, 0);
        rst_n = 1'b1;

        while (frames_seen < n_frames && cycles < 50000) begin
            if (frames_seen >= 5) stall_mode = 1;
            cycle();
        end
        if (cycles >= 50000) check(1'b0, "R10 watchdog expired", frames_seen, n_frames);

        // R11: idle with no input produces nothing
        in_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            if (out_valid || frame_done)
                check(1'b0, "R11 output while idle", out_valid, 0);
        end
        check(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
        check(frames_seen == n_frames, "R10 frame count", frames_seen, n_frames);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule